// File: doc/BRIEF.md
# Serial Configuration PROM Pin Port

This block gives a processor register-level control over the wires of small three-wire serial configuration PROMs, the kind whose read and write protocol firmware produces by toggling pins. There is one PROM on the main board and up to four PROMs on plug-in modules. Each group has its own register. A write sets the chip-select, serial-clock and data-in levels, and the pin outputs keep those levels until the next write to the same register. A read returns the levels set by the last write, together with the data-out level the PROM is driving now. That level is passed through a synchronizer before it appears in the read value.

The module register also carries a slot number. It routes the clock, chip-select and data-in levels to one module PROM only, and it picks which PROM's data-out is read back. Every unselected slot sees all three of its pins held low. When the selected slot has no module present, its data-out bit reads as 1. As an option, the main-board read value can also carry a fixed chassis-type flag.

Top module: `ser_prom_port`

## Requirements
- R1: While reset is asserted and after it is released, and before any write, every pin output (mb_cs, mb_sclk, mb_di, nm_cs, nm_sclk, nm_di) is low and the module slot number is 0.
- R2: A write to MB_ADDR sets mb_cs from wdata bit 0, mb_sclk from bit 1 and mb_di from bit 2, starting at the clock edge that takes the write. A read of MB_ADDR returns these levels in the same bit positions.
- R3: Bit 3 of a MB_ADDR read is the mb_do input after a two-flop synchronizer. A change on mb_do shows in the read value after the second rising clock edge, and not after the first.
- R4: A write to NM_ADDR sets the module clock from wdata bit 2, chip-select from bit 4 and data-in from bit 6, and sets the slot number from bits 1:0. A read of NM_ADDR returns the clock in bit 2, chip-select in bit 4 and data-in in bit 6.
- R5: The module pin levels appear only on the vector bit of the selected slot (nm_cs[slot], nm_sclk[slot], nm_di[slot]). All other slots see all three of their pins low.
- R6: Bit 7 of a NM_ADDR read is the synchronized nm_do of the selected slot when nm_present of that slot is 1, and reads 1 when it is 0. It uses the same two-edge latency as R3.
- R7: Bits that carry no pin function read as 0: bits 6:4 and all bits above 7 of a MB_ADDR read, and bits 1:0, 3, 5 and all bits above 7 of a NM_ADDR read.
- R8: With CHASSIS_TAG_EN=1, bit 7 of a MB_ADDR read equals CHASSIS_TAG_VAL (1 for an enterprise chassis, 0 for a telco chassis). With CHASSIS_TAG_EN=0 it reads 0. The defaults are 1 and 1.
- R9: A write to any address other than MB_ADDR and NM_ADDR leaves every pin output and the slot number unchanged, and a write to one of the two registers leaves the other group's pins unchanged. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe; takes reg_wdata at the rising edge |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| mb_cs | output | 1 | Main-board PROM chip-select |
| mb_sclk | output | 1 | Main-board PROM serial clock |
| mb_di | output | 1 | Main-board PROM data-in |
| mb_do | input | 1 | Main-board PROM data-out (asynchronous) |
| nm_cs | output | SLOTS | Module PROM chip-selects, one per slot |
| nm_sclk | output | SLOTS | Module PROM serial clocks, one per slot |
| nm_di | output | SLOTS | Module PROM data-in, one per slot |
| nm_do | input | SLOTS | Module PROM data-out, one per slot (asynchronous) |
| nm_present | input | SLOTS | Module present flags, 1 = present |

## Verification
The hardest case to reach is a read of the module data-out from a slot that is selected but absent, while the absent slot's own data-out wire is driven low. Only then does the forced 1 differ from the wire's level. The bench sets up this case directly. It also mixes random present masks with random data-out vectors and random slot selections, so that every slot is read both present and absent with both wire levels. Synchronizer latency is probed by changing mb_do and reading one edge later and then two edges later.

// File: rtl/prom_port_pkg.sv
package prom_port_pkg;
   // Bit positions in the main-board register (fixed by firmware)
   localparam int MB_CS_B   = 0;
   localparam int MB_SK_B   = 1;
   localparam int MB_DI_B   = 2;
   localparam int MB_DO_B   = 3;
   localparam int MB_TAG_B  = 7;
   // Bit positions in the module register
   localparam int NM_SEL_LO = 0;
   localparam int NM_SEL_W  = 2;
   localparam int NM_SK_B   = 2;
   localparam int NM_CS_B   = 4;
   localparam int NM_DI_B   = 6;
   localparam int NM_DO_B   = 7;
   localparam int REG_W     = 8;

   typedef struct packed {
      logic cs;
      logic sk;
      logic di;
   } prom_pins_t;
endpackage

// File: rtl/prom_sync.sv
module prom_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("prom_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/prom_mb_port.sv
module prom_mb_port
   import prom_port_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter bit CHASSIS_TAG_EN  = 1'b1,
   parameter bit CHASSIS_TAG_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             do_in,
   output prom_pins_t       pins,
   output logic [REG_W-1:0] rd
);
   prom_pins_t pins_q;
   logic       do_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q <= '0;
      end else if (wr) begin
         pins_q.cs <= wdata[MB_CS_B];
         pins_q.sk <= wdata[MB_SK_B];
         pins_q.di <= wdata[MB_DI_B];
      end
   end

   prom_sync #(.W(1), .STAGES(SYNC_STAGES)) u_do_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (do_in),
      .q     (do_s)
   );

   logic tag_bit;
   if (CHASSIS_TAG_EN) begin : g_tag
      assign tag_bit = CHASSIS_TAG_VAL;
   end else begin : g_no_tag
      assign tag_bit = 1'b0;
   end

   always_comb begin
      rd           = '0;
      rd[MB_CS_B]  = pins_q.cs;
      rd[MB_SK_B]  = pins_q.sk;
      rd[MB_DI_B]  = pins_q.di;
      rd[MB_DO_B]  = do_s;
      rd[MB_TAG_B] = tag_bit;
   end

   assign pins = pins_q;
endmodule

// File: rtl/prom_nm_port.sv
module prom_nm_port
   import prom_port_pkg::*;
#(
   parameter int SLOTS       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [SLOTS-1:0] do_in,
   input  logic [SLOTS-1:0] present,
   output logic [SLOTS-1:0] cs_o,
   output logic [SLOTS-1:0] sk_o,
   output logic [SLOTS-1:0] di_o,
   output logic [REG_W-1:0] rd
);
   localparam int MAX_SLOTS = 1 << NM_SEL_W;

   if (SLOTS < 1 || SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("prom_nm_port: SLOTS out of range for the select field");
   end

   prom_pins_t          pins_q;
   logic [NM_SEL_W-1:0] slot_q;
   logic [SLOTS-1:0]    do_s;
   logic                do_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins_q <= '0;
         slot_q <= '0;
      end else if (wr) begin
         pins_q.cs <= wdata[NM_CS_B];
         pins_q.sk <= wdata[NM_SK_B];
         pins_q.di <= wdata[NM_DI_B];
         slot_q    <= wdata[NM_SEL_LO +: NM_SEL_W];
      end
   end

   prom_sync #(.W(SLOTS), .STAGES(SYNC_STAGES)) u_do_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (do_in),
      .q     (do_s)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_fan
      logic hit;
      assign hit     = (slot_q == NM_SEL_W'(s));
      assign cs_o[s] = hit & pins_q.cs;
      assign sk_o[s] = hit & pins_q.sk;
      assign di_o[s] = hit & pins_q.di;
   end

   // Absent or nonexistent slot reads data-out high
   always_comb begin
      do_sel = 1'b1;
      for (int s = 0; s < SLOTS; s++) begin
         if (slot_q == NM_SEL_W'(s) && present[s]) do_sel = do_s[s];
      end
   end

   always_comb begin
      rd          = '0;
      rd[NM_SK_B] = pins_q.sk;
      rd[NM_CS_B] = pins_q.cs;
      rd[NM_DI_B] = pins_q.di;
      rd[NM_DO_B] = do_sel;
   end
endmodule

// File: rtl/ser_prom_port.sv
module ser_prom_port
   import prom_port_pkg::*;
#(
   parameter int              DATA_W          = 16,
   parameter int              ADDR_W          = 4,
   parameter logic [ADDR_W-1:0] MB_ADDR       = 4'h0,
   parameter logic [ADDR_W-1:0] NM_ADDR       = 4'h1,
   parameter int              SLOTS           = 4,
   parameter int              SYNC_STAGES     = 2,
   parameter bit              CHASSIS_TAG_EN  = 1'b1,
   parameter bit              CHASSIS_TAG_VAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mb_cs,
   output logic              mb_sclk,
   output logic              mb_di,
   input  logic              mb_do,
   output logic [SLOTS-1:0]  nm_cs,
   output logic [SLOTS-1:0]  nm_sclk,
   output logic [SLOTS-1:0]  nm_di,
   input  logic [SLOTS-1:0]  nm_do,
   input  logic [SLOTS-1:0]  nm_present
);
   if (DATA_W < REG_W) begin : g_bad_width
      $error("ser_prom_port: DATA_W must be at least 8");
   end
   if (MB_ADDR == NM_ADDR) begin : g_bad_addr
      $error("ser_prom_port: register addresses must differ");
   end

   logic             hit_mb, hit_nm;
   logic [REG_W-1:0] wbyte, rd_mb, rd_nm;
   prom_pins_t       mb_pins;

   assign hit_mb = (reg_addr == MB_ADDR);
   assign hit_nm = (reg_addr == NM_ADDR);
   assign wbyte  = reg_wdata[REG_W-1:0];

   prom_mb_port #(
      .SYNC_STAGES     (SYNC_STAGES),
      .CHASSIS_TAG_EN  (CHASSIS_TAG_EN),
      .CHASSIS_TAG_VAL (CHASSIS_TAG_VAL)
   ) u_mb (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr & hit_mb),
      .wdata (wbyte),
      .do_in (mb_do),
      .pins  (mb_pins),
      .rd    (rd_mb)
   );

   prom_nm_port #(
      .SLOTS       (SLOTS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_nm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr & hit_nm),
      .wdata   (wbyte),
      .do_in   (nm_do),
      .present (nm_present),
      .cs_o    (nm_cs),
      .sk_o    (nm_sclk),
      .di_o    (nm_di),
      .rd      (rd_nm)
   );

   assign mb_cs   = mb_pins.cs;
   assign mb_sclk = mb_pins.sk;
   assign mb_di   = mb_pins.di;

   always_comb begin
      reg_rdata = '0;
      if (hit_mb)      reg_rdata[REG_W-1:0] = rd_mb;
      else if (hit_nm) reg_rdata[REG_W-1:0] = rd_nm;
   end
endmodule

// File: rtl/prom_port_chk.sv
module prom_port_chk #(
   parameter int                DATA_W  = 16,
   parameter int                ADDR_W  = 4,
   parameter logic [ADDR_W-1:0] MB_ADDR = 4'h0,
   parameter logic [ADDR_W-1:0] NM_ADDR = 4'h1,
   parameter int                SLOTS   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              mb_cs,
   input logic              mb_sclk,
   input logic              mb_di,
   input logic [SLOTS-1:0]  nm_cs,
   input logic [SLOTS-1:0]  nm_sclk,
   input logic [SLOTS-1:0]  nm_di
);
   logic mapped;
   assign mapped = (reg_addr == MB_ADDR) || (reg_addr == NM_ADDR);

   AST_MB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == MB_ADDR) |=> (mb_cs == $past(reg_wdata[0]) &&
      mb_sclk == $past(reg_wdata[1]) && mb_di == $past(reg_wdata[2]))); // R2

   AST_NM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == NM_ADDR) |=> ((|nm_cs) == $past(reg_wdata[4]) &&
      (|nm_sclk) == $past(reg_wdata[2]) && (|nm_di) == $past(reg_wdata[6]))); // R4

   AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nm_cs | nm_sclk | nm_di)); // R5

   AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && mapped) |=> ($stable(nm_cs) && $stable(nm_sclk) && $stable(nm_di) &&
      $stable(mb_cs) && $stable(mb_sclk) && $stable(mb_di))); // R9

   AST_MB_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == MB_ADDR) |-> (reg_rdata[6:4] == 3'b000 && (reg_rdata >> 8) == '0)); // R7

   AST_NM_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == NM_ADDR) |-> (reg_rdata[1:0] == 2'b00 && reg_rdata[3] == 1'b0 &&
      reg_rdata[5] == 1'b0 && (reg_rdata >> 8) == '0)); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (reg_rdata == '0)); // R9
endmodule

bind ser_prom_port prom_port_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .MB_ADDR (MB_ADDR),
   .NM_ADDR (NM_ADDR),
   .SLOTS   (SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .mb_cs     (mb_cs),
   .mb_sclk   (mb_sclk),
   .mb_di     (mb_di),
   .nm_cs     (nm_cs),
   .nm_sclk   (nm_sclk),
   .nm_di     (nm_di)
);

// File: tb/ser_prom_port_bench.sv
module ser_prom_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int NS = 4;
   localparam logic [AW-1:0] A_MB  = 4'h0;
   localparam logic [AW-1:0] A_NM  = 4'h1;
   localparam logic [AW-1:0] A_BAD = 4'h5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          mb_cs, mb_sclk, mb_di;
   logic          mb_do = 1'b0;
   logic [NS-1:0] nm_cs, nm_sclk, nm_di;
   logic [NS-1:0] nm_do = '0;
   logic [NS-1:0] nm_present = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model
   logic [2:0] m_mb;   // {di, sk, cs}
   logic [2:0] m_nm;   // {di, sk, cs}
   logic [1:0] m_slot;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_prom_port u_ser_prom_port (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .mb_cs (mb_cs), .mb_sclk (mb_sclk), .mb_di (mb_di), .mb_do (mb_do),
      .nm_cs (nm_cs), .nm_sclk (nm_sclk), .nm_di (nm_di), .nm_do (nm_do),
      .nm_present (nm_present)
   );

   function automatic logic [DW-1:0] exp_mb(logic doo);
      // R2 R3 R8: bit7 tag=1, bit3 do, bits 2:0 di,sk,cs
      return DW'({1'b1, 3'b000, doo, m_mb[2], m_mb[1], m_mb[0]});
   endfunction

   function automatic logic [DW-1:0] exp_nm();
      logic d;
      d = nm_present[m_slot] ? nm_do[m_slot] : 1'b1;  // R6
      return DW'({d, m_nm[2], 1'b0, m_nm[0], 1'b0, m_nm[1], 2'b00});
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_check(logic [AW-1:0] a, string req, logic [DW-1:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic pins_check(string req);
      logic [NS-1:0] sel;
      sel = NS'(1) << m_slot;
      check(req, DW'({mb_di, mb_sclk, mb_cs}), DW'(m_mb));
      check(req, DW'({nm_cs, nm_sclk, nm_di}),
            DW'({m_nm[0] ? sel : '0, m_nm[1] ? sel : '0, m_nm[2] ? sel : '0}));
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == A_MB) m_mb = {d[2], d[1], d[0]};
      else if (a == A_NM) begin
         m_nm = {d[6], d[2], d[4]};
         m_slot = d[1:0];
      end
   endtask

   task automatic full_check();
      rd_check(A_MB, "R2/R3/R8", exp_mb(mb_do));
      rd_check(A_NM, "R4/R6/R7", exp_nm());
      rd_check(A_BAD, "R9", '0);
      pins_check("R5/R9");
   endtask

   initial begin
      int unsigned seed_use;
      seed_use = $urandom(32'd7341);
      m_mb = '0; m_nm = '0; m_slot = '0;
      // R1: reset state
      #(CLK_PERIOD*2);
      pins_check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      pins_check("R1");
      rd_check(A_NM, "R1", exp_nm());   // slot 0 absent -> do reads 1

      // R3: two-edge latency on mb_do
      @(negedge clk);
      mb_do = 1'b1;
      @(negedge clk);
      rd_check(A_MB, "R3 one edge", exp_mb(1'b0));
      @(negedge clk);
      rd_check(A_MB, "R3 two edges", exp_mb(1'b1));

      // R2: main-board pins, extra bits ignored
      wr(A_MB, 16'hFFF5);
      full_check();
      // R4 R5: select slot 2, all pins high
      wr(A_NM, 16'h00D6);
      full_check();
      // R6: slot 2 absent, wire low -> reads 1
      nm_do = 4'b0000; nm_present = 4'b1011;
      repeat (3) @(negedge clk);
      rd_check(A_NM, "R6 absent", exp_nm());
      // R6: slot 2 present, wire low -> reads 0
      nm_present = 4'b1111;
      repeat (3) @(negedge clk);
      rd_check(A_NM, "R6 present", exp_nm());
      // R9: writes elsewhere change nothing
      wr(A_BAD, 16'hFFFF);
      full_check();
      wr(A_NM, 16'h0003);
      full_check();
      wr(A_MB, 16'h0000);
      pins_check("R9 other group");

      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned op;
         op = $urandom_range(0, 4);
         case (op)
            0: wr(A_MB, DW'($urandom));
            1: wr(A_NM, DW'($urandom));
            2: wr(AW'($urandom_range(2, 15)), DW'($urandom));
            default: begin
               @(negedge clk);
               mb_do = 1'($urandom);
               nm_do = NS'($urandom);
               nm_present = NS'($urandom);
               repeat (3) @(negedge clk);
            end
         endcase
         full_check();
      end
      done = 1'b1;
   end

   initial begin
      int cyc;
      for (cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule